// File: doc/BRIEF.md
# ALU Operand Bypass Unit

This block sits at the ALU stage of a five-stage in-order pipeline. When the pipeline advances, it latches the instruction entering the ALU stage. That latch holds the two source register numbers (first and second operand), an immediate-form flag and the two operand values read from the register file. The block then compares the two source numbers against the destination numbers of the two older instructions further down the pipe, one in the memory stage and one in the write-back stage. If an older instruction will write a register the ALU-stage instruction reads, the block steers that instruction's pending result to the ALU input in place of the stale latched value.

The memory-stage result register can forward only when it already holds a final value, which is an ALU result or a load-address result. A load in the memory stage has not read memory yet, so it never forwards from there. The write-back result register can forward for every class that writes a register: ALU, load-address, load and branch-and-link. When both older stages match the same source, the memory stage wins because it carries the younger result. An immediate-form instruction takes its second operand from the constant, so forwarding on that path is suppressed. With this network, two dependent ALU instructions can issue back to back without a stall. Stalls for a load followed at once by its consumer belong to the hazard detector, not to this block.

The two operand paths and the stage-ALU latch form internal pipeline state with a plain advance enable. There is no valid/ready handshake, because the surrounding pipeline owns flow control.

Top module: `alu_bypass_unit`

## Requirements
- R1: After reset the ALU-stage latch is empty (`s3_valid`=0), both selects read 00, and `alu_x`/`alu_y` are zero.
- R2: On a rising edge with `adv`=1 the latch takes `s2_valid`, `s2_rb`, `s2_rc`, `s2_imm`, `s2_x`, `s2_y`. With `adv`=0 it holds its contents.
- R3: If the write-back instruction's class writes a register (ALU=1, LADR=2, LOAD=3, BRL=6) and `s5_ra` equals the latched first source, `x_sel`=10 and `alu_x`=`s5_z`, unless R5 applies.
- R4: Under the same class rule, if `s5_ra` equals the latched second source and the instruction is not immediate-form, `y_sel`=10 and `alu_y`=`s5_z`, unless R5 applies.
- R5: If the memory-stage class is ALU (1) or LADR (2) and `s4_ra` equals a latched source, that operand's select is 01 and its value is `s4_z` (second operand only when not immediate-form).
- R6: When the memory and write-back stages both qualify for the same source, the memory stage (01) is chosen.
- R7: A memory-stage instruction of class NONE=0, LOAD=3, STORE=4, BRANCH=5 or BRL=6 never forwards. The select then falls back to the write-back rule or to 00. In the write-back stage, NONE, STORE and BRANCH never forward.
- R8: With `s2_imm`=1 latched, `y_sel` stays 00 and `alu_y` equals the latched second operand, whatever the matches. The first operand path is unaffected.
- R9: With the latch empty (`s3_valid`=0) both selects are 00 and the latched operands pass through.
- R10: Select codes are 00 latched operand, 01 memory-stage result, 10 write-back result. The code 11 never appears, and each ALU operand equals the source its select names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv | input | 1 | Pipeline advance: load the ALU-stage latch |
| s2_valid | input | 1 | Incoming instruction is real (not a bubble) |
| s2_rb | input | REG_AW | Incoming first source register number |
| s2_rc | input | REG_AW | Incoming second source register number |
| s2_imm | input | 1 | Incoming instruction uses an immediate second operand |
| s2_x | input | DATA_W | Incoming first operand value |
| s2_y | input | DATA_W | Incoming second operand value (register or constant) |
| s4_cls | input | 3 | Memory-stage instruction class |
| s4_ra | input | REG_AW | Memory-stage destination register |
| s4_z | input | DATA_W | Memory-stage result register |
| s5_cls | input | 3 | Write-back instruction class |
| s5_ra | input | REG_AW | Write-back destination register |
| s5_z | input | DATA_W | Write-back result register |
| s3_valid | output | 1 | ALU-stage latch holds an instruction |
| x_sel | output | 2 | First operand select |
| y_sel | output | 2 | Second operand select |
| alu_x | output | DATA_W | First ALU operand after bypass |
| alu_y | output | DATA_W | Second ALU operand after bypass |

## Verification
A wrong latch entry or a broken comparator shows at once as a wrong select code and a wrong operand value. The bypass path is combinational from the stage-4/5 ports, so the error appears in the same cycle as the stimulus. A latch fault shows in the first cycle after the advancing edge. The sweep covers every pair of source numbers and both immediate settings against every class and destination combination of both older stages, so any faulty priority, class filter or immediate mask gives a mismatched select within a few nanoseconds of the bad input.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LADR   = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_BRL    = 3'd6
  } op_class_e;

  localparam logic [1:0] SEL_LATCH = 2'b00;
  localparam logic [1:0] SEL_MEM   = 2'b01;
  localparam logic [1:0] SEL_WB    = 2'b10;

  // Class leaves a register result by write-back time.
  function automatic logic writes_reg(input logic [2:0] cls);
    return (cls == CLS_ALU) || (cls == CLS_LADR) ||
           (cls == CLS_LOAD) || (cls == CLS_BRL);
  endfunction

  // Class holds its final result already in the memory-stage register.
  function automatic logic result_ready_mem(input logic [2:0] cls);
    return (cls == CLS_ALU) || (cls == CLS_LADR);
  endfunction
endpackage

// File: rtl/fwd_stage3_reg.sv
module fwd_stage3_reg #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [REG_AW-1:0] in_rb,
  input  logic [REG_AW-1:0] in_rc,
  input  logic              in_imm,
  input  logic [DATA_W-1:0] in_x,
  input  logic [DATA_W-1:0] in_y,
  output logic              q_valid,
  output logic [REG_AW-1:0] q_rb,
  output logic [REG_AW-1:0] q_rc,
  output logic              q_imm,
  output logic [DATA_W-1:0] q_x,
  output logic [DATA_W-1:0] q_y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_rb    <= '0;
      q_rc    <= '0;
      q_imm   <= 1'b0;
      q_x     <= '0;
      q_y     <= '0;
    end else if (adv) begin
      q_valid <= in_valid;
      q_rb    <= in_rb;
      q_rc    <= in_rc;
      q_imm   <= in_imm;
      q_x     <= in_x;
      q_y     <= in_y;
    end
  end
endmodule

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              src_en,
  input  logic [REG_AW-1:0] src,
  input  logic              mem_ok,
  input  logic [REG_AW-1:0] mem_ra,
  input  logic              wb_ok,
  input  logic [REG_AW-1:0] wb_ra,
  output logic [1:0]        sel
);
  logic hit_mem, hit_wb;

  assign hit_mem = src_en && mem_ok && (mem_ra == src);
  assign hit_wb  = src_en && wb_ok  && (wb_ra  == src);

  // Younger result (memory stage) takes precedence.
  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_LATCH;
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] latched,
  input  logic [DATA_W-1:0] mem_z,
  input  logic [DATA_W-1:0] wb_z,
  output logic [DATA_W-1:0] operand
);
  always_comb begin
    unique case (sel)
      SEL_MEM: operand = mem_z;
      SEL_WB:  operand = wb_z;
      default: operand = latched;
    endcase
  end
endmodule

// File: rtl/alu_bypass_unit.sv
module alu_bypass_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              s2_valid,
  input  logic [REG_AW-1:0] s2_rb,
  input  logic [REG_AW-1:0] s2_rc,
  input  logic              s2_imm,
  input  logic [DATA_W-1:0] s2_x,
  input  logic [DATA_W-1:0] s2_y,
  input  logic [2:0]        s4_cls,
  input  logic [REG_AW-1:0] s4_ra,
  input  logic [DATA_W-1:0] s4_z,
  input  logic [2:0]        s5_cls,
  input  logic [REG_AW-1:0] s5_ra,
  input  logic [DATA_W-1:0] s5_z,
  output logic              s3_valid,
  output logic [1:0]        x_sel,
  output logic [1:0]        y_sel,
  output logic [DATA_W-1:0] alu_x,
  output logic [DATA_W-1:0] alu_y
);
  localparam int N_OPND = 2;

  logic [REG_AW-1:0] s3_rb, s3_rc;
  logic              s3_imm;
  logic [DATA_W-1:0] s3_x, s3_y;

  fwd_stage3_reg #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_s3 (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_valid(s2_valid), .in_rb(s2_rb), .in_rc(s2_rc), .in_imm(s2_imm),
    .in_x(s2_x), .in_y(s2_y),
    .q_valid(s3_valid), .q_rb(s3_rb), .q_rc(s3_rc), .q_imm(s3_imm),
    .q_x(s3_x), .q_y(s3_y)
  );

  logic mem_ok, wb_ok;
  assign mem_ok = result_ready_mem(s4_cls);
  assign wb_ok  = writes_reg(s5_cls);

  logic [REG_AW-1:0] src   [N_OPND];
  logic              src_en[N_OPND];
  logic [DATA_W-1:0] lat   [N_OPND];
  logic [1:0]        sel   [N_OPND];
  logic [DATA_W-1:0] opnd  [N_OPND];

  assign src[0]    = s3_rb;
  assign src[1]    = s3_rc;
  assign src_en[0] = s3_valid;
  assign src_en[1] = s3_valid && !s3_imm;
  assign lat[0]    = s3_x;
  assign lat[1]    = s3_y;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fwd_match #(.REG_AW(REG_AW)) u_match (
      .src_en(src_en[g]), .src(src[g]),
      .mem_ok(mem_ok), .mem_ra(s4_ra),
      .wb_ok(wb_ok), .wb_ra(s5_ra),
      .sel(sel[g])
    );
    fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel(sel[g]), .latched(lat[g]), .mem_z(s4_z), .wb_z(s5_z),
      .operand(opnd[g])
    );
  end

  assign x_sel = sel[0];
  assign y_sel = sel[1];
  assign alu_x = opnd[0];
  assign alu_y = opnd[1];
endmodule

// File: rtl/alu_bypass_unit_chk.sv
module alu_bypass_unit_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic [REG_AW-1:0] s2_rb,
  input logic [2:0]        s4_cls,
  input logic [REG_AW-1:0] s4_ra,
  input logic [DATA_W-1:0] s4_z,
  input logic [DATA_W-1:0] s5_z,
  input logic              s3_valid,
  input logic [REG_AW-1:0] s3_rb,
  input logic              s3_imm,
  input logic [1:0]        x_sel,
  input logic [1:0]        y_sel,
  input logic [DATA_W-1:0] alu_x,
  input logic [DATA_W-1:0] alu_y
);
  assert_sel_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sel != 2'b11) && (y_sel != 2'b11));

  assert_x_from_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sel == 2'b01) |-> (alu_x == s4_z));

  assert_y_from_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (y_sel == 2'b01) |-> (alu_y == s4_z));

  assert_x_from_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sel == 2'b10) |-> (alu_x == s5_z));

  assert_y_from_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (y_sel == 2'b10) |-> (alu_y == s5_z));

  assert_mem_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((x_sel == 2'b01) || (y_sel == 2'b01)) |-> ((s4_cls == 3'd1) || (s4_cls == 3'd2)));

  assert_mem_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_valid && ((s4_cls == 3'd1) || (s4_cls == 3'd2)) && (s4_ra == s3_rb))
      |-> (x_sel == 2'b01));

  assert_imm_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s3_imm |-> (y_sel == 2'b00));

  assert_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s3_valid |-> ((x_sel == 2'b00) && (y_sel == 2'b00)));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (s3_rb == $past(s2_rb)));
endmodule

bind alu_bypass_unit alu_bypass_unit_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .s2_rb(s2_rb),
  .s4_cls(s4_cls), .s4_ra(s4_ra), .s4_z(s4_z), .s5_z(s5_z),
  .s3_valid(s3_valid), .s3_rb(s3_rb), .s3_imm(s3_imm),
  .x_sel(x_sel), .y_sel(y_sel), .alu_x(alu_x), .alu_y(alu_y)
);

// File: tb/test_alu_bypass_unit.sv
module test_alu_bypass_unit;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int NREG = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv = 1'b0, s2_valid = 1'b0, s2_imm = 1'b0;
  logic [AW-1:0] s2_rb = '0, s2_rc = '0, s4_ra = '0, s5_ra = '0;
  logic [DW-1:0] s2_x = '0, s2_y = '0, s4_z = 8'hC4, s5_z = 8'hD5;
  logic [2:0] s4_cls = 3'd0, s5_cls = 3'd0;
  logic s3_valid;
  logic [1:0] x_sel, y_sel;
  logic [DW-1:0] alu_x, alu_y;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu_bypass_unit #(.DATA_W(DW), .REG_AW(AW)) i_alu_bypass_unit (
    .clk(clk), .rst_n(rst_n), .adv(adv), .s2_valid(s2_valid),
    .s2_rb(s2_rb), .s2_rc(s2_rc), .s2_imm(s2_imm), .s2_x(s2_x), .s2_y(s2_y),
    .s4_cls(s4_cls), .s4_ra(s4_ra), .s4_z(s4_z),
    .s5_cls(s5_cls), .s5_ra(s5_ra), .s5_z(s5_z),
    .s3_valid(s3_valid), .x_sel(x_sel), .y_sel(y_sel),
    .alu_x(alu_x), .alu_y(alu_y)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit wr5(input int c);
    return (c == 1) || (c == 2) || (c == 3) || (c == 6);
  endfunction
  function automatic bit rdy4(input int c);
    return (c == 1) || (c == 2);
  endfunction

  task automatic load(input bit v, input int rb, input int rc, input bit im,
                      input int x, input int y);
    @(negedge clk);
    s2_valid = v; s2_rb = AW'(rb); s2_rc = AW'(rc); s2_imm = im;
    s2_x = DW'(x); s2_y = DW'(y); adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state, with a stage-4 ALU match presented
    s4_cls = 3'd1; s4_ra = '0;
    #7;
    check("R1 s3_valid", int'(s3_valid), 0);
    check("R1 x_sel", int'(x_sel), 0);
    check("R1 y_sel", int'(y_sel), 0);
    check("R1 alu_x", int'(alu_x), 0);
    check("R1 alu_y", int'(alu_y), 0);
    rst_n = 1'b1;
    s4_cls = 3'd0;

    // R9: bubble latched, matches present -> selects 00, latched values pass
    load(1'b0, 1, 2, 1'b0, 8'h3A, 8'h3B);
    s4_cls = 3'd1; s4_ra = 2'd1; s5_cls = 3'd1; s5_ra = 2'd2;
    #1;
    check("R9 x_sel", int'(x_sel), 0);
    check("R9 y_sel", int'(y_sel), 0);
    check("R9 alu_x", int'(alu_x), 8'h3A);
    check("R9 alu_y", int'(alu_y), 8'h3B);

    // R2: capture then hold while adv is low
    load(1'b1, 3, 0, 1'b0, 8'h51, 8'h52);
    s4_cls = 3'd0; s5_cls = 3'd0;
    s2_rb = 2'd1; s2_x = 8'h77; s2_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R2 hold x", int'(alu_x), 8'h51);
    check("R2 hold y", int'(alu_y), 8'h52);
    check("R2 hold valid", int'(s3_valid), 1);
    s4_cls = 3'd1; s4_ra = 2'd3; #1;
    check("R2 held rb matches", int'(x_sel), 1);
    s4_ra = 2'd1; #1;
    check("R2 new rb not latched", int'(x_sel), 0);
    s4_cls = 3'd0;

    // Exhaustive sweep: every source pair, imm flag, class and destination
    for (int rb = 0; rb < NREG; rb++)
      for (int rc = 0; rc < NREG; rc++)
        for (int im = 0; im < 2; im++) begin
          int xv, yv;
          xv = 8'hA0 | (rb << 2) | rc;
          yv = 8'h60 | (rb << 2) | rc;
          load(1'b1, rb, rc, im[0], xv, yv);
          for (int c4 = 0; c4 < 7; c4++)
            for (int a4 = 0; a4 < NREG; a4++)
              for (int c5 = 0; c5 < 7; c5++)
                for (int a5 = 0; a5 < NREG; a5++) begin
                  int ex, ey;
                  bit m4x, m5x, m4y, m5y;
                  string tx, ty;
                  s4_cls = 3'(c4); s4_ra = AW'(a4);
                  s5_cls = 3'(c5); s5_ra = AW'(a5);
                  #1;
                  m4x = rdy4(c4) && (a4 == rb);
                  m5x = wr5(c5) && (a5 == rb);
                  m4y = rdy4(c4) && (a4 == rc) && (im == 0);
                  m5y = wr5(c5) && (a5 == rc) && (im == 0);
                  ex = m4x ? 1 : (m5x ? 2 : 0);
                  ey = m4y ? 1 : (m5y ? 2 : 0);
                  if (m4x && m5x) tx = "R6";
                  else if (m4x) tx = "R5";
                  else if (a4 == rb && c4 != 0) tx = "R7";
                  else if (m5x) tx = "R3";
                  else tx = "R10";
                  if (im == 1) ty = "R8";
                  else if (m4y && m5y) ty = "R6";
                  else if (m4y) ty = "R5";
                  else if (m5y) ty = "R4";
                  else ty = "R10";
                  check({tx, " x_sel"}, int'(x_sel), ex);
                  check({ty, " y_sel"}, int'(y_sel), ey);
                  check({tx, " alu_x"}, int'(alu_x),
                        ex == 1 ? 8'hC4 : (ex == 2 ? 8'hD5 : xv));
                  check({ty, " alu_y"}, int'(alu_y),
                        ey == 1 ? 8'hC4 : (ey == 2 ? 8'hD5 : yv));
                end
        end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule